// File: doc/BRIEF.md
# Cache Line Refill Controller

This block fills one cache line of 16 words (32 bits each, 64 bytes in total) from a main memory after a cache miss. The memory sits inside the block as a fixed-latency timing model. Every access takes 10 cycles and every bus transfer takes 1 cycle. Sending the line address to memory takes one cycle before the first access begins.

The memory model can be organized in one of three ways, chosen per request. In the narrow organization, memory and bus are one word wide. In the wide organization, memory and bus are four words wide. In the banked organization there are four interleaved banks, each one word wide, that share a one-word bus. The controller runs the matching sequence of accesses and transfers. It writes every returned word into the line buffer, in ascending offset order. When the line is complete it pulses `done` and reports how many cycles the refill took.

The miss request is a valid/ready input. `req_ready` is high exactly when the controller is idle. A request held while the controller is busy is neither accepted nor stored. The requester stays stalled until `req_ready` returns. The line-buffer write port has no back-pressure: the buffer must accept every strobe in the cycle it is presented.

Top module: `line_refill_ctrl`

## Requirements
- R1: After a synchronous active-high `rst` (at start-up or in the middle of a refill), `busy` and `done` are 0, `cycles` is 0, `req_ready` is 1 and `wr_lane_en` is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. `req_mode` and `req_line` are captured at that edge. `busy` is high from the next cycle on.
- R3: Mode 0 (narrow) makes 16 single-word writes, one lane each, with offsets 0,1,…,15. Write t appears 12+11·t cycles after the accept edge.
- R4: Mode 1 (wide) makes 4 writes with all four lanes enabled, at base offsets 0,4,8,12. Lane i carries offset base+i. Write t appears 12+11·t cycles after the accept edge.
- R5: Mode 2 (banked) makes 16 single-lane writes with offsets 0…15, in four bursts of four consecutive cycles. Burst a starts 12+14·a cycles after the accept edge.
- R6: Mode 3 behaves exactly like mode 0.
- R7: The word at offset o of line L has the value {L, o}: line address in the upper bits, 4-bit offset in the low bits, zero-extended to 32 bits. Disabled lanes read 0.
- R8: While `busy` is high, `req_ready` is low, and a held request changes neither the line being filled nor the mode.
- R9: `done` is a one-cycle pulse, due P+1 cycles after the accept edge, where P is 177, 45 or 57 for modes 0/3, 1 and 2. In the `done` cycle, `cycles` equals P.
- R10: `busy` stays high up to and including the `done` cycle. It is low, with `req_ready` high, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle; request will be taken |
| req_mode | input | 2 | Memory organization: 0 narrow, 1 wide, 2 banked, 3 as 0 |
| req_line | input | 26 | Line address of the miss |
| busy | output | 1 | Refill in progress |
| wr_lane_en | output | 4 | Per-lane write strobe for the line buffer |
| wr_base | output | 4 | Offset of lane 0; lane i writes offset wr_base+i |
| wr_data | output | 128 | Lane data, lane i in bits 32·i+31 to 32·i |
| done | output | 1 | One-cycle line-complete pulse |
| cycles | output | 10 | Cycle count of the refill, valid with done |

## Verification
Every result is tied to a cycle number k counted from the accept edge. Write strobes are due at cycle 1 + (a+1)·10 + a·beats + b + 1 for access a and beat b. `done` is due at P+1, and idle at P+2. The bench derives each of these cycle numbers from the mode with plain arithmetic. It samples on the falling edge of each cycle k, so each strobe must fall in exactly its computed cycle. A strobe that arrives early or late is a failure, and so is one with a wrong lane or offset. Held requests during a refill are checked by comparing every later data word against the first line address.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ORG_NARROW = 2'd0,
    ORG_WIDE   = 2'd1,
    ORG_BANKED = 2'd2,
    ORG_RSVD   = 2'd3
  } mem_org_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_ACCESS = 3'd2,
    ST_XFER   = 3'd3,
    ST_DONE   = 3'd4
  } refill_st_e;
endpackage

// File: rtl/refill_access_timer.sv
module refill_access_timer #(
  parameter int ACC_LAT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic last
);
  localparam int LW = $clog2(ACC_LAT + 1);
  logic [LW-1:0] cnt;

  assign last = active && (cnt == LW'(ACC_LAT - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || last) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/refill_bank_read.sv
module refill_bank_read #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 26,
  parameter int OFF_W  = 4,
  parameter int BANKS  = 4
) (
  input  logic                    xfer,
  input  logic                    wide,
  input  logic [ADDR_W-1:0]       line,
  input  logic [OFF_W-1:0]        base,
  output logic [BANKS-1:0]        lane_en,
  output logic [BANKS*WORD_W-1:0] lane_data
);
  for (genvar i = 0; i < BANKS; i++) begin : g_lane
    logic [OFF_W-1:0] off_i;
    assign off_i = base + OFF_W'(i);
    if (i == 0) begin : g_first
      assign lane_en[i] = xfer;
    end else begin : g_rest
      assign lane_en[i] = xfer && wide;
    end
    assign lane_data[i*WORD_W +: WORD_W] =
      lane_en[i] ? WORD_W'({line, off_i}) : '0;
  end
endmodule

// File: rtl/refill_cycle_counter.sv
module refill_cycle_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (en)    count <= count + 1'b1;
  end
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import refill_pkg::*;
#(
  parameter int LINE_WORDS = 16,
  parameter int WORD_W     = 32,
  parameter int BANKS      = 4,
  parameter int ACC_LAT    = 10,
  parameter int ADDR_W     = 26,
  parameter int CNT_W      = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_mode,
  input  logic [ADDR_W-1:0]       req_line,
  output logic                    busy,
  output logic [BANKS-1:0]        wr_lane_en,
  output logic [$clog2(LINE_WORDS)-1:0] wr_base,
  output logic [BANKS*WORD_W-1:0] wr_data,
  output logic                    done,
  output logic [CNT_W-1:0]        cycles
);
  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int BEAT_W  = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int GROUPS  = LINE_WORDS / BANKS;
  localparam int P_NARROW = 1 + LINE_WORDS * (ACC_LAT + 1);
  localparam int P_WIDE   = 1 + GROUPS * (ACC_LAT + 1);
  localparam int P_BANKED = 1 + GROUPS * (ACC_LAT + BANKS);

  refill_st_e        state;
  mem_org_e          mode_q;
  logic [ADDR_W-1:0] line_q;
  logic [OFF_W-1:0]  off_q;
  logic [BEAT_W-1:0] beat_q;
  logic              accept, acc_last, last_beat, line_end, in_xfer;
  logic [OFF_W:0]    step;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign done      = (state == ST_DONE);
  assign in_xfer   = (state == ST_XFER);
  assign step      = (mode_q == ORG_WIDE) ? (OFF_W+1)'(BANKS) : (OFF_W+1)'(1);
  assign last_beat = (mode_q != ORG_BANKED) || (beat_q == BEAT_W'(BANKS - 1));
  assign line_end  = ({1'b0, off_q} + step) == (OFF_W+1)'(LINE_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= ORG_NARROW;
      line_q <= '0;
      off_q  <= '0;
      beat_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_ADDR;
          mode_q <= (mem_org_e'(req_mode) == ORG_RSVD) ? ORG_NARROW : mem_org_e'(req_mode);
          line_q <= req_line;
          off_q  <= '0;
          beat_q <= '0;
        end
        ST_ADDR:   state <= ST_ACCESS;
        ST_ACCESS: if (acc_last) state <= ST_XFER;
        ST_XFER: begin
          off_q <= off_q + step[OFF_W-1:0];
          if (last_beat) begin
            beat_q <= '0;
            state  <= line_end ? ST_DONE : ST_ACCESS;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  refill_access_timer #(.ACC_LAT(ACC_LAT)) u_timer (
    .clk(clk), .rst(rst), .active(state == ST_ACCESS), .last(acc_last)
  );

  refill_bank_read #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANKS(BANKS)) u_read (
    .xfer(in_xfer), .wide(mode_q == ORG_WIDE), .line(line_q), .base(off_q),
    .lane_en(wr_lane_en), .lane_data(wr_data)
  );

  assign wr_base = off_q;

  refill_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(accept),
    .en(state == ST_ADDR || state == ST_ACCESS || in_xfer), .count(cycles)
  );

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (wr_lane_en == '0)); // R1
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(line_q) && $stable(mode_q))); // R8
  AST_ONE_LANE_NARROW: assert property (@(posedge clk) disable iff (rst)
    (mode_q != ORG_WIDE) |-> $onehot0(wr_lane_en)); // R3
  AST_PENALTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles == ((mode_q == ORG_WIDE)   ? CNT_W'(P_WIDE)   :
                         (mode_q == ORG_BANKED) ? CNT_W'(P_BANKED) : CNT_W'(P_NARROW)))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy)); // R10
  AST_ACCESS_GAP: assert property (@(posedge clk) disable iff (rst)
    acc_last |=> in_xfer); // R5
endmodule

// File: tb/tb_line_refill_ctrl.sv
`timescale 1ns/1ps
module tb_line_refill_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_mode = 2'd0;
  logic [25:0]  req_line = '0;
  logic         busy;
  logic [3:0]   wr_lane_en;
  logic [3:0]   wr_base;
  logic [127:0] wr_data;
  logic         done;
  logic [9:0]   cycles;

  int n_vec  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  line_refill_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_line(req_line), .busy(busy),
    .wr_lane_en(wr_lane_en), .wr_base(wr_base), .wr_data(wr_data),
    .done(done), .cycles(cycles)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(busy == 1'b0, req, busy, 0);
    chk(done == 1'b0, req, done, 0);
    chk(req_ready == 1'b1, req, req_ready, 1);
    chk(wr_lane_en == 4'd0, req, wr_lane_en, 0);
  endtask

  task automatic run_refill(input int mode, input logic [25:0] line, input bit spam);
    int eff   = (mode == 3) ? 0 : mode;
    int step  = (eff == 1) ? 4 : 1;
    int beats = (eff == 2) ? 4 : 1;
    int ntr   = 16 / step;
    int pen   = 1 + (ntr / beats) * (10 + beats);
    int t     = 0;
    string rq = (eff == 0) ? ((mode == 3) ? "R6" : "R3") : (eff == 1) ? "R4" : "R5";
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", req_ready, 1);
    req_valid = 1'b1;
    req_mode  = 2'(mode);
    req_line  = line;
    for (int k = 1; k <= pen + 2; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (spam) begin
          req_line = ~line;
          req_mode = 2'(mode ^ 1);
        end else begin
          req_valid = 1'b0;
        end
        chk(busy == 1'b1, "R2", busy, 1);
      end
      if (k == 20) req_valid = 1'b0;
      if (k >= 1 && k <= pen + 1 && req_valid)
        chk(req_ready == 1'b0, "R8", req_ready, 0);
      begin
        int a = t / beats;
        int b = t % beats;
        int due = (t < ntr) ? (1 + (a + 1) * 10 + a * beats + b + 1) : -1;
        if (k == due) begin
          logic [3:0] exp_en = (step == 4) ? 4'hF : 4'h1;
          chk(wr_lane_en == exp_en, rq, wr_lane_en, exp_en);
          chk(wr_base == 4'(t * step), rq, wr_base, t * step);
          for (int i = 0; i < 4; i++) begin
            logic [31:0] exp_d = exp_en[i] ? {2'b00, line, 4'(t * step + i)} : 32'd0;
            chk(wr_data[i*32 +: 32] == exp_d, spam ? "R8" : "R7", wr_data[i*32 +: 32], exp_d);
          end
          t++;
        end else begin
          chk(wr_lane_en == 4'd0, rq, wr_lane_en, 0);
        end
      end
      if (k == pen + 1) begin
        chk(done == 1'b1, "R9", done, 1);
        chk(cycles == 10'(pen), "R9", cycles, pen);
        chk(busy == 1'b1, "R10", busy, 1);
      end else if (k == pen + 2) begin
        chk_idle("R10");
      end else begin
        chk(done == 1'b0, "R9", done, 0);
      end
    end
    chk(t == ntr, rq, t, ntr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [25:0] lines [4];
    lines[0] = 26'h0000000;
    lines[1] = 26'h0000001;
    lines[2] = 26'h3FFFFFF;
    lines[3] = 26'h1555555;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk_idle("R1");
    chk(cycles == 10'd0, "R1", cycles, 0);
    for (int m = 0; m < 4; m++)
      for (int j = 0; j < 4; j++)
        run_refill(m, lines[j], j == 3);
    // R1: reset in the middle of a refill
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd2; req_line = 26'h0ABCDEF;
    repeat (30) @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R1");
    chk(cycles == 10'd0, "R1", cycles, 0);
    run_refill(1, 26'h2222222, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule